// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block holds the software-visible control state for two bus-master DMA channels. It sits behind a simple 32-bit register bus with byte lane enables. Each channel keeps a command byte, a 6-bit scratch byte for software, a status byte and a 32-bit descriptor table pointer. The command byte drives an external DMA engine through start and direction outputs, and a one-cycle start pulse. The engine reports back through per-channel pulses for completion, error and interrupt. Software can read a packed combined word that gathers both channels' command, status and device interrupt state in one access.

The status byte holds three kinds of bit. One is controlled by hardware, two are plain read/write and two are sticky flags that software clears by writing a one. A second window of byte offsets takes writes exactly like the per-channel control words, so software that uses the combined view can also write through it.

Top module: `bmdma_regbank`

## Requirements
- R1: After a synchronous active-low reset, every stored field is zero, rdata is zero, and start_pulse, cmd_start, cmd_dir and tbl_ptr are all zero.
- R2: The command byte (offset 0x00 for channel 0, 0x08 for channel 1) stores only bit 0 (start) and bit 3 (direction). Every other command bit reads as zero. The stored bits appear on cmd_start and cmd_dir.
- R3: A command write that moves start from 0 to 1 raises that channel's start_pulse for exactly the one cycle after the write edge. Writing start=1 while start is already 1 produces no pulse.
- R4: The scratch byte (offset 0x01 / 0x09) keeps written bits 5:0 and reads bits 7:6 as zero.
- R5: A status write (offset 0x02 / 0x0A) loads bits 6:5 from the data, leaves bit 0 unchanged and clears bit 2 and bit 1 only where the data bit is 1. Bits 7, 4 and 3 read as zero.
- R6: An eng_err pulse sets status bit 1 and an eng_irq pulse sets status bit 2. When a set and a clear by write-one land in the same cycle, the set wins.
- R7: Status bit 0 (active) becomes 1 together with the start pulse. It becomes 0 on an eng_done pulse or on a command write with start=0, and the write takes precedence.
- R8: The table pointer (offsets 0x04-0x07 / 0x0C-0x0F) is written one byte lane at a time under the byte enables. Bits 1:0 always read as zero and appear so on tbl_ptr.
- R9: Writes to word 0x10 (byte lanes 0-2) act exactly like writes to offsets 0x00-0x02, and writes to word 0x18 act like writes to 0x08-0x0A. Lane 3 of these words is ignored.
- R10: A read of 0x10 returns the channel 0 command in bits 7:0, with channel 0 dev_irq ORed into bit 4 and channel 1 dev_irq into bit 6. Bit 14 is channel 1 status bit 2, bits 23:16 are the channel 0 status and bits 31:24 are the channel 1 status.
- R11: A read of 0x18 returns the channel 1 command in bits 7:0 with channel 1 dev_irq in bit 4, and the channel 1 status in bits 23:16.
- R12: Byte offsets 0x03 and 0x0B, words 0x14 and 0x1C, and all addresses at 0x20 and above read as zero. Writes there change no state.
- R13: rdata is registered. It presents the value addressed by a read in the cycle after rd_en and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte lane enables for writes |
| rdata | output | 32 | Registered read data |
| eng_done | input | 2 | Per-channel transfer-finished pulse |
| eng_err | input | 2 | Per-channel error pulse |
| eng_irq | input | 2 | Per-channel interrupt pulse |
| dev_irq | input | 2 | Per-channel device interrupt pending level |
| start_pulse | output | 2 | One-cycle start request per channel |
| cmd_start | output | 2 | Stored start bit per channel |
| cmd_dir | output | 2 | Stored direction bit per channel |
| tbl_ptr | output | 64 | Descriptor table pointers, channel 1 in the upper half |

## Verification
Every write and every engine pulse takes effect at the clock edge that samples it. The stored state, cmd_start, cmd_dir and tbl_ptr therefore change one cycle later, and start_pulse is high for just that cycle. A read's rdata arrives one edge after rd_en, while dev_irq is combined at the moment of the read. The bench drives every stimulus on the falling edge and samples one full cycle later, on the next falling edge. It checks the start pulse at that sample and again one cycle after to confirm it has dropped. It runs same-cycle set-and-clear and same-cycle hold cases so that precedence shows at the ports.

// File: rtl/bmdma_pkg.sv
// Package: shared constants and types for the DMA register bank.
// Assumes two channels; the address map is fixed around that count.
package bmdma_pkg;
    localparam int NCH    = 2;
    localparam int DATA_W = 32;
    localparam int NBYTE  = DATA_W / 8;

    // status byte bit positions
    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_IRQ = 2;

    // per-channel write strobes produced by the address decoder
    typedef struct packed {
        logic             cmd_we;
        logic             scr_we;
        logic             st_we;
        logic [NBYTE-1:0] ptr_be;
    } chan_wr_t;

    // per-channel register view presented to the read mux
    typedef struct packed {
        logic [7:0]        cmd;
        logic [7:0]        scratch;
        logic [7:0]        status;
        logic [DATA_W-1:0] ptr;
    } chan_view_t;
endpackage

// File: rtl/bmdma_decode.sv
// Module: write address decoder.
// Turns a bus write into per-channel byte strobes. The control word of a
// channel answers at its own word and at its alias word 16 bytes higher;
// lane 3 of a control word is never decoded. Assumes word addressing
// (byte address bits 1:0 are dropped by the caller).
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:2]     waddr,
    input  logic [NBYTE-1:0]      be,
    output chan_wr_t [NCH-1:0]    wr
);
    localparam int WORD_W = 3;

    logic              in_win;
    logic [WORD_W-1:0] word;
    logic [NCH-1:0]    ctl_hit;
    logic [NCH-1:0]    ptr_hit;

    // purpose: window check and word index extraction
    always_comb begin
        in_win = (waddr[ADDR_W-1:5] == '0);
        word   = waddr[4:2];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [WORD_W-1:0] CTL_W   = WORD_W'(2 * c);
        localparam logic [WORD_W-1:0] ALIAS_W = WORD_W'(2 * c + 4);
        localparam logic [WORD_W-1:0] PTR_W   = WORD_W'(2 * c + 1);

        // purpose: per-channel strobes from hit and byte lanes
        always_comb begin
            ctl_hit[c]       = wr_en && in_win && (word == CTL_W || word == ALIAS_W);
            ptr_hit[c]       = wr_en && in_win && (word == PTR_W);
            wr[c].cmd_we     = ctl_hit[c] && be[0];
            wr[c].scr_we     = ctl_hit[c] && be[1];
            wr[c].st_we      = ctl_hit[c] && be[2];
            wr[c].ptr_be     = ptr_hit[c] ? be : '0;
        end
    end

    // at most one channel control word is addressed per write
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_hit, ptr_hit})); // R9
endmodule

// File: rtl/bmdma_chan.sv
// Module: one DMA channel's register set.
// Holds command, scratch, status and table pointer; emits a start pulse on
// a 0-to-1 start transition. Engine pulses are one cycle wide and set the
// sticky status flags; set beats a same-cycle write-one clear.
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              err,
    input  logic              irq,
    output chan_view_t        view,
    output logic              start_pulse,
    output logic              start,
    output logic              dir
);
    logic              start_q, dir_q, pulse_q;
    logic [5:0]        scr_q;
    logic              act_q, err_q, irq_q;
    logic [1:0]        st_rw_q;
    logic [DATA_W-1:2] ptr_q;
    logic              start_rise;
    logic              start_clr;

    // purpose: detect start edges from the command write
    always_comb begin
        start_rise = wr.cmd_we && wdata[0] && !start_q;
        start_clr  = wr.cmd_we && !wdata[0];
    end

    // purpose: command bits and start pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (wr.cmd_we) begin
                start_q <= wdata[0];
                dir_q   <= wdata[3];
            end
            pulse_q <= start_rise;
        end
    end

    // purpose: scratch byte, low six bits only
    always_ff @(posedge clk) begin
        if (!rst_n) scr_q <= '0;
        else if (wr.scr_we) scr_q <= wdata[13:8];
    end

    // purpose: active bit, set with start, cleared by done or start=0 write
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else if (start_clr) act_q <= 1'b0;
        else if (start_rise) act_q <= 1'b1;
        else if (done) act_q <= 1'b0;
    end

    // purpose: sticky error and interrupt flags plus read/write status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            st_rw_q <= '0;
        end else begin
            err_q <= err || (err_q && !(wr.st_we && wdata[16 + ST_ERR]));
            irq_q <= irq || (irq_q && !(wr.st_we && wdata[16 + ST_IRQ]));
            if (wr.st_we) st_rw_q <= wdata[22:21];
        end
    end

    // purpose: byte-lane writes to the descriptor table pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            if (wr.ptr_be[0]) ptr_q[7:2] <= wdata[7:2];
            for (int b = 1; b < NBYTE; b++) begin
                if (wr.ptr_be[b]) ptr_q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    // purpose: assemble the software-visible view and engine outputs
    always_comb begin
        view.cmd     = {4'b0, dir_q, 2'b0, start_q};
        view.scratch = {2'b0, scr_q};
        view.status  = {1'b0, st_rw_q, 2'b0, irq_q, err_q, act_q};
        view.ptr     = {ptr_q, 2'b00};
        start_pulse  = pulse_q;
        start        = start_q;
        dir          = dir_q;
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R3
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.cmd_we && wdata[0] && !start) |=> (start_pulse && start)); // R3
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> view.status[ST_ERR]); // R6
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> view.status[ST_IRQ]); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (view.status[ST_ERR] && !(wr.st_we && wdata[16 + ST_ERR])) |=> view.status[ST_ERR]); // R5
    AST_ACT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.cmd_we && !wdata[0]) |=> !view.status[ST_ACT]); // R7
    AST_ACT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr.cmd_we && !done) |=> $stable(view.status[ST_ACT])); // R5
endmodule

// File: rtl/bmdma_rdmux.sv
// Module: read data multiplexer with registered output.
// Selects a per-channel word, a pointer, or one of the combined views, and
// captures it on rd_en; rdata holds between reads. Device interrupt levels
// are sampled at the read.
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:2]     raddr,
    input  chan_view_t [NCH-1:0]  view,
    input  logic [NCH-1:0]        dev_irq,
    output logic [DATA_W-1:0]     rdata
);
    logic              in_win;
    logic [2:0]        word;
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] rdata_q;

    // purpose: choose the addressed word
    always_comb begin
        in_win = (raddr[ADDR_W-1:5] == '0);
        word   = raddr[4:2];
        sel    = '0;
        if (in_win) begin
            case (word)
                3'd0: sel = {8'h00, view[0].status, view[0].scratch, view[0].cmd};
                3'd1: sel = view[0].ptr;
                3'd2: sel = {8'h00, view[1].status, view[1].scratch, view[1].cmd};
                3'd3: sel = view[1].ptr;
                3'd4: begin
                    sel         = {view[1].status, view[0].status, 8'h00, view[0].cmd};
                    sel[4]      = view[0].cmd[4] | dev_irq[0];
                    sel[6]      = view[0].cmd[6] | dev_irq[1];
                    sel[14]     = view[1].status[ST_IRQ];
                end
                3'd6: begin
                    sel         = {8'h00, view[1].status, 8'h00, view[1].cmd};
                    sel[4]      = view[1].cmd[4] | dev_irq[1];
                end
                default: sel = '0;
            endcase
        end
    end

    // purpose: capture read data on rd_en, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_en) rdata_q <= sel;
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R13
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (!in_win || word == 3'd5 || word == 3'd7)) |=> (rdata == '0)); // R12
    AST_GAP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_win && (word == 3'd0 || word == 3'd2)) |=> (rdata[31:24] == 8'h00)); // R12
endmodule

// File: rtl/bmdma_regbank.sv
// Module: dual-channel bus-master DMA register bank (top).
// Connects the write decoder, two channel register sets and the read mux.
// Assumes a single-cycle register bus: writes land at the sampling edge,
// reads return one cycle later on rdata.
module bmdma_regbank
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NBYTE-1:0]        be,
    output logic [DATA_W-1:0]       rdata,
    input  logic [NCH-1:0]          eng_done,
    input  logic [NCH-1:0]          eng_err,
    input  logic [NCH-1:0]          eng_irq,
    input  logic [NCH-1:0]          dev_irq,
    output logic [NCH-1:0]          start_pulse,
    output logic [NCH-1:0]          cmd_start,
    output logic [NCH-1:0]          cmd_dir,
    output logic [NCH*DATA_W-1:0]   tbl_ptr
);
    chan_wr_t   [NCH-1:0] wr;
    chan_view_t [NCH-1:0] view;

    bmdma_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .waddr (addr[ADDR_W-1:2]),
        .be    (be),
        .wr    (wr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bmdma_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr          (wr[c]),
            .wdata       (wdata),
            .done        (eng_done[c]),
            .err         (eng_err[c]),
            .irq         (eng_irq[c]),
            .view        (view[c]),
            .start_pulse (start_pulse[c]),
            .start       (cmd_start[c]),
            .dir         (cmd_dir[c])
        );
        assign tbl_ptr[c*DATA_W +: DATA_W] = view[c].ptr;
    end

    bmdma_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .raddr   (addr[ADDR_W-1:2]),
        .view    (view),
        .dev_irq (dev_irq),
        .rdata   (rdata)
    );

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_ptr[1:0] == 2'b00) && (tbl_ptr[DATA_W+1:DATA_W] == 2'b00)); // R8
    AST_NO_WRITE_NO_CMD_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cmd_start) && $stable(cmd_dir) && $stable(tbl_ptr))); // R12
endmodule

// File: tb/bmdma_regbank_test.sv
// Bench: table-driven register checks, then directed tests for engine
// pulses, start pulse timing, precedence, read hold and reset.
module bmdma_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic [1:0]  eng_done = '0, eng_err = '0, eng_irq = '0, dev_irq = '0;
    logic [1:0]  start_pulse, cmd_start, cmd_dir;
    logic [63:0] tbl_ptr;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmdma_regbank #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .eng_done(eng_done),
        .eng_err(eng_err), .eng_irq(eng_irq), .dev_irq(dev_irq),
        .start_pulse(start_pulse), .cmd_start(cmd_start), .cmd_dir(cmd_dir),
        .tbl_ptr(tbl_ptr)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  req;
        logic [7:0]  a;
        logic [3:0]  b;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 4'd2,  8'h00, 4'b0001, 32'h0000_00FF, 32'h0},          // R2 cmd keeps bits 0,3
        '{1'b1, 4'd2,  8'h00, 4'b0000, 32'h0,         32'h0001_0009},  // R2 R7
        '{1'b0, 4'd4,  8'h01, 4'b0010, 32'h0000_FF00, 32'h0},          // R4
        '{1'b0, 4'd5,  8'h02, 4'b0100, 32'h00FF_0000, 32'h0},          // R5
        '{1'b1, 4'd5,  8'h00, 4'b0000, 32'h0,         32'h0061_3F09},  // R4 R5
        '{1'b0, 4'd12, 8'h03, 4'b1000, 32'hFF00_0000, 32'h0},          // R12 gap byte
        '{1'b1, 4'd12, 8'h00, 4'b0000, 32'h0,         32'h0061_3F09},  // R12
        '{1'b0, 4'd8,  8'h04, 4'b1111, 32'h1234_5677, 32'h0},          // R8
        '{1'b0, 4'd8,  8'h05, 4'b0010, 32'h0000_AB00, 32'h0},          // R8 lane 1 only
        '{1'b1, 4'd8,  8'h04, 4'b0000, 32'h0,         32'h1234_AB74},  // R8
        '{1'b0, 4'd9,  8'h18, 4'b1111, 32'hAAC0_2008, 32'h0},          // R9 alias ch1
        '{1'b1, 4'd9,  8'h08, 4'b0000, 32'h0,         32'h0040_2008},  // R9
        '{1'b1, 4'd11, 8'h18, 4'b0000, 32'h0,         32'h0040_0008},  // R11
        '{1'b1, 4'd10, 8'h10, 4'b0000, 32'h0,         32'h4061_0009},  // R10
        '{1'b0, 4'd12, 8'h14, 4'b1111, 32'hFFFF_FFFF, 32'h0},          // R12
        '{1'b0, 4'd12, 8'h1C, 4'b1111, 32'hFFFF_FFFF, 32'h0},          // R12
        '{1'b0, 4'd12, 8'h44, 4'b1111, 32'hFFFF_FFFF, 32'h0},          // R12
        '{1'b1, 4'd12, 8'h14, 4'b0000, 32'h0,         32'h0},          // R12
        '{1'b1, 4'd12, 8'h44, 4'b0000, 32'h0,         32'h0},          // R12
        '{1'b1, 4'd12, 8'h0C, 4'b0000, 32'h0,         32'h0},          // R12 ptr1 untouched
        '{1'b0, 4'd7,  8'h10, 4'b0001, 32'h0000_0000, 32'h0},          // R7 R9 clear start
        '{1'b1, 4'd7,  8'h00, 4'b0000, 32'h0,         32'h0060_3F00},  // R7
        '{1'b0, 4'd8,  8'h0C, 4'b1111, 32'hFFFF_FFFF, 32'h0}           // R8
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; be = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [1:0] dn, input logic [1:0] er, input logic [1:0] iq);
        @(negedge clk);
        eng_done = dn; eng_err = er; eng_irq = iq;
        @(negedge clk);
        eng_done = '0; eng_err = '0; eng_irq = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", {32'h0, rdata}, 64'h0);
        check("R1 outputs", {58'h0, start_pulse, cmd_start, cmd_dir}, 64'h0);
        check("R1 tbl_ptr", tbl_ptr, 64'h0);
        rst_n = 1'b1;
        bus_read(8'h10, r);
        check("R1 combined", {32'h0, r}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                bus_read(VEC[i].a, r);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), {32'h0, r}, {32'h0, VEC[i].exp});
            end else begin
                bus_write(VEC[i].a, VEC[i].b, VEC[i].d);
            end
        end
        check("R8 tbl_ptr port", tbl_ptr, 64'hFFFF_FFFC_1234_AB74);
        check("R2 cmd ports", {60'h0, cmd_start, cmd_dir}, {60'h0, 2'b00, 2'b10});

        // R3 start pulse on ch1 rise, one cycle only
        bus_write(8'h08, 4'b0001, 32'h0000_0001);
        check("R3 pulse high", {62'h0, start_pulse}, 64'h2);
        check("R2 start/dir", {60'h0, cmd_start, cmd_dir}, {60'h0, 2'b10, 2'b00});
        @(negedge clk);
        check("R3 pulse low", {62'h0, start_pulse}, 64'h0);
        bus_write(8'h08, 4'b0001, 32'h0000_0001);
        check("R3 no repulse", {62'h0, start_pulse}, 64'h0);

        // R6 engine pulses set sticky flags
        pulse(2'b00, 2'b10, 2'b10);
        bus_read(8'h08, r);
        check("R6 ch1 status", {32'h0, r}, 64'h0047_2001);
        bus_read(8'h10, r);
        check("R10 bit14", {32'h0, r}, 64'h4760_4000);

        // R5 write-one clears irq only; R11 through alias read
        bus_write(8'h1A, 4'b0100, 32'h0044_0000);
        bus_read(8'h18, r);
        check("R5 R11 w1c irq", {32'h0, r}, 64'h0043_0001);

        // R6 set beats same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h0A; be = 4'b0100; wdata = 32'h0042_0000; eng_err = 2'b10;
        @(negedge clk);
        wr_en = 1'b0; be = '0; eng_err = '0;
        bus_read(8'h08, r);
        check("R6 set wins", {32'h0, r}, 64'h0043_2001);
        bus_write(8'h0A, 4'b0100, 32'h0042_0000);
        bus_read(8'h08, r);
        check("R5 w1c err", {32'h0, r}, 64'h0041_2001);

        // R7 done clears active
        pulse(2'b10, 2'b00, 2'b00);
        bus_read(8'h08, r);
        check("R7 done", {32'h0, r}, 64'h0040_2001);

        // R10 R11 device interrupt levels
        dev_irq = 2'b11;
        bus_read(8'h10, r);
        check("R10 devirq", {32'h0, r}, 64'h4060_0050);
        bus_read(8'h18, r);
        check("R11 devirq", {32'h0, r}, 64'h0040_0011);
        bus_read(8'h00, r);
        check("R10 ch word clean", {32'h0, r}, 64'h0060_3F00);
        dev_irq = 2'b00;

        // R13 rdata holds without rd_en
        bus_write(8'h01, 4'b0010, 32'h0000_0500);
        @(negedge clk);
        check("R13 hold", {32'h0, rdata}, 64'h0060_3F00);
        bus_read(8'h00, r);
        check("R13 new read", {32'h0, r}, 64'h0060_0500);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rerst rdata", {32'h0, rdata}, 64'h0);
        check("R1 rerst ports", {58'h0, start_pulse, cmd_start, cmd_dir}, 64'h0);
        check("R1 rerst ptr", tbl_ptr, 64'h0);
        rst_n = 1'b1;
        bus_read(8'h08, r);
        check("R1 rerst ch1", {32'h0, r}, 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule